// File: doc/BRIEF.md
# Programmable Memory Chip-Select Decoder

This block turns the upper byte of a 20-bit CPU address into two active-low memory selects, one for ROM and one for RAM. The windows are set at run time by three 8-bit boundary registers, so each boundary moves in steps of 4 KB. The ROM window runs from the bottom of memory up to and including its upper bound. The RAM window lies between a lower and an upper bound, both inclusive. Where the two windows overlap, ROM wins.

Software programs the bounds and a configuration register through an 8-bit I/O port. An I/O access selects a register by the low address byte alone. The configuration register holds two control bits. One turns the ROM select off, so that RAM can shadow the ROM area. The other makes internal register reads visible on the external data bus, which helps a bus monitor or emulator follow the program.

The select outputs depend only on the address and the registers. They are not gated by any strobe, so they can glitch while the address bus settles.

Top module: `csdec_top`

## Requirements
- R1: After reset the ROM bound reads FFh, and the RAM lower bound, RAM upper bound and configuration register all read 00h. Every address then asserts the ROM select and leaves the RAM select high.
- R2: While `io_wr` is high, the register at the low address byte loads `wdata` on the rising clock edge. The register addresses are EAh (RAM upper bound), EBh (RAM lower bound), ECh (ROM upper bound) and EDh (configuration). While `io_rd` is high at one of these addresses, `rdata` shows that register's contents in the same cycle.
- R3: Register selection compares only `addr[7:0]`, and all eight bits must match. An access whose low byte is none of the four addresses changes no register. Bits 19 to 8 do not take part in register selection.
- R4: `rom_cs_n` is low exactly when `addr[19:12]` is at most the ROM upper bound and the ROM-off bit is clear.
- R5: `ram_cs_n` is low exactly when `addr[19:12]` lies between the RAM lower and upper bounds, both inclusive, and `rom_cs_n` is high. The two selects are never low together.
- R6: Both selects are combinational in the address and registers. `io_rd` and `io_wr` have no effect on them.
- R7: Configuration bit 5 is the ROM-off bit. When it is set, `rom_cs_n` stays high. Only bits 5 and 1 of the configuration register are stored, and its other bits read 0.
- R8: Configuration bit 1 is the expose bit. `dbus_oe` is high exactly when `io_rd` is high, the low address byte names a register, and the expose bit is set.
- R9: `rdata` is 00h whenever `io_rd` is low or the low address byte names no register.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 20 | CPU address. Bits 19:12 drive the select decode; bits 7:0 give the I/O register address |
| io_rd | input | 1 | I/O read strobe, active high |
| io_wr | input | 1 | I/O write strobe, active high |
| wdata | input | 8 | Data written to a register |
| rdata | output | 8 | Register read data |
| rom_cs_n | output | 1 | ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low |
| dbus_oe | output | 1 | Enables the external data bus driver during an internal read |

## Verification
A bound register that holds the wrong value moves a window edge by whole 4 KB pages. The bench therefore probes pages exactly at each bound and one page beyond it. Any such error shows on `rom_cs_n` or `ram_cs_n` in the same cycle the address is applied. A write that lands in the wrong register, or that aliases from an unlisted address, shows up on the next read-back or boundary probe after that write. A lost configuration bit shows up at once on `dbus_oe` during an exposed read, or as a ROM select that fails to turn off.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
    localparam int AW     = 20;  // CPU address width
    localparam int DW     = 8;   // I/O data width
    localparam int PAGEW  = 8;   // address bits compared for the selects
    localparam int IOAW   = 8;   // address bits decoded for I/O registers
    localparam int NREG   = 4;

    localparam logic [IOAW-1:0] ADR_RAM_HI = 8'hEA;
    localparam logic [IOAW-1:0] ADR_RAM_LO = 8'hEB;
    localparam logic [IOAW-1:0] ADR_ROM_HI = 8'hEC;
    localparam logic [IOAW-1:0] ADR_CFG    = 8'hED;

    localparam int CFG_ROMOFF_BIT = 5;
    localparam int CFG_EXPOSE_BIT = 1;

    typedef enum logic [1:0] {
        IDX_RAM_HI = 2'd0,
        IDX_RAM_LO = 2'd1,
        IDX_ROM_HI = 2'd2,
        IDX_CFG    = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic [PAGEW-1:0] ram_hi;
        logic [PAGEW-1:0] ram_lo;
        logic [PAGEW-1:0] rom_hi;
        logic             rom_off;
        logic             expose;
    } csdec_regs_t;

    localparam csdec_regs_t REGS_RESET = '{
        ram_hi:  '0,
        ram_lo:  '0,
        rom_hi:  '1,
        rom_off: 1'b0,
        expose:  1'b0
    };
endpackage

// File: rtl/csdec_regs.sv
module csdec_regs
    import csdec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IOAW-1:0] io_addr,
    input  logic            io_rd,
    input  logic            io_wr,
    input  logic [DW-1:0]   wdata,
    output csdec_regs_t     regs,
    output logic [DW-1:0]   rdata,
    output logic            hit
);
    localparam logic [NREG-1:0][IOAW-1:0] REG_ADR =
        {ADR_CFG, ADR_ROM_HI, ADR_RAM_LO, ADR_RAM_HI};

    logic [NREG-1:0] sel;
    csdec_regs_t     regs_d, regs_q;

    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign sel[i] = (io_addr == REG_ADR[i]);
    end

    assign hit = |sel;

    always_comb begin
        regs_d = regs_q;
        if (io_wr) begin
            if (sel[IDX_RAM_HI]) regs_d.ram_hi = wdata[PAGEW-1:0];
            if (sel[IDX_RAM_LO]) regs_d.ram_lo = wdata[PAGEW-1:0];
            if (sel[IDX_ROM_HI]) regs_d.rom_hi = wdata[PAGEW-1:0];
            if (sel[IDX_CFG]) begin
                regs_d.rom_off = wdata[CFG_ROMOFF_BIT];
                regs_d.expose  = wdata[CFG_EXPOSE_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RESET;
        else        regs_q <= regs_d;
    end

    always_comb begin
        rdata = '0;
        if (io_rd) begin
            if (sel[IDX_RAM_HI]) rdata = regs_q.ram_hi;
            if (sel[IDX_RAM_LO]) rdata = regs_q.ram_lo;
            if (sel[IDX_ROM_HI]) rdata = regs_q.rom_hi;
            if (sel[IDX_CFG]) begin
                rdata[CFG_ROMOFF_BIT] = regs_q.rom_off;
                rdata[CFG_EXPOSE_BIT] = regs_q.expose;
            end
        end
    end

    assign regs = regs_q;
endmodule

// File: rtl/csdec_match.sv
module csdec_match
    import csdec_pkg::*;
(
    input  logic [PAGEW-1:0] page,
    input  csdec_regs_t      regs,
    output logic             rom_cs_n,
    output logic             ram_cs_n
);
    logic in_rom, in_ram;

    always_comb begin
        in_rom   = (page <= regs.rom_hi) && !regs.rom_off;
        in_ram   = (page >= regs.ram_lo) && (page <= regs.ram_hi);
        rom_cs_n = !in_rom;
        ram_cs_n = !(in_ram && !in_rom);
    end
endmodule

// File: rtl/csdec_top.sv
module csdec_top
    import csdec_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          io_rd,
    input  logic          io_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rom_cs_n,
    output logic          ram_cs_n,
    output logic          dbus_oe
);
    csdec_regs_t cfg_regs;
    logic        reg_hit;
    logic        unused_mid;

    assign unused_mid = ^addr[AW-PAGEW-1:IOAW];

    csdec_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_addr (addr[IOAW-1:0]),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .wdata   (wdata),
        .regs    (cfg_regs),
        .rdata   (rdata),
        .hit     (reg_hit)
    );

    csdec_match u_match (
        .page     (addr[AW-1 -: PAGEW]),
        .regs     (cfg_regs),
        .rom_cs_n (rom_cs_n),
        .ram_cs_n (ram_cs_n)
    );

    assign dbus_oe = io_rd && reg_hit && cfg_regs.expose;
endmodule

// File: rtl/csdec_chk.sv
module csdec_chk
    import csdec_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          io_rd,
    input logic          io_wr,
    input logic [DW-1:0] wdata,
    input logic          rom_cs_n,
    input logic          ram_cs_n,
    input logic          dbus_oe,
    input csdec_regs_t   regs
);
    // R5
    sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rom_cs_n && !ram_cs_n));

    // R4
    rom_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_cs_n |-> (addr[AW-1 -: PAGEW] <= regs.rom_hi));

    // R5
    ram_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cs_n |-> (addr[AW-1 -: PAGEW] >= regs.ram_lo &&
                       addr[AW-1 -: PAGEW] <= regs.ram_hi));

    // R7
    rom_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs.rom_off |-> rom_cs_n);

    // R8
    oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe |-> (io_rd && regs.expose));

    // R2
    rom_hi_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && addr[IOAW-1:0] == ADR_ROM_HI) |=> regs.rom_hi == $past(wdata));

    // R2
    ram_lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && addr[IOAW-1:0] == ADR_RAM_LO) |=> regs.ram_lo == $past(wdata));
endmodule

bind csdec_top csdec_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .wdata    (wdata),
    .rom_cs_n (rom_cs_n),
    .ram_cs_n (ram_cs_n),
    .dbus_oe  (dbus_oe),
    .regs     (cfg_regs)
);

// File: tb/csdec_top_bench.sv
module csdec_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rom_cs_n, ram_cs_n, dbus_oe;

    typedef struct {
        logic       rom_n;
        logic       ram_n;
        logic       oe;
        logic [7:0] rd;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    csdec_top u_csdec_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .io_rd(io_rd), .io_wr(io_wr),
        .wdata(wdata), .rdata(rdata), .rom_cs_n(rom_cs_n),
        .ram_cs_n(ram_cs_n), .dbus_oe(dbus_oe)
    );

    task automatic wr(input logic [19:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic chk(input logic [19:0] a, input logic rd,
                       input logic rom_n, input logic ram_n, input logic oe,
                       input logic [7:0] rv, input string tag);
        exp_t e;
        @(posedge clk); #1;
        addr = a; io_rd = rd; io_wr = 1'b0;
        e.rom_n = rom_n; e.ram_n = ram_n; e.oe = oe; e.rd = rv; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: pops one expected item per cycle and compares mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (rom_cs_n !== e.rom_n || ram_cs_n !== e.ram_n ||
                    dbus_oe !== e.oe || rdata !== e.rd) begin
                    n_fail++;
                    $display("FAIL %s: got rom_n=%b ram_n=%b oe=%b rdata=%h expected rom_n=%b ram_n=%b oe=%b rdata=%h",
                             e.tag, rom_cs_n, ram_cs_n, dbus_oe, rdata,
                             e.rom_n, e.ram_n, e.oe, e.rd);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk(20'hFFFFF, 0, 0, 1, 0, 8'h00, "R1 top page is ROM");
        chk(20'h00000, 0, 0, 1, 0, 8'h00, "R1 page 0 ROM over RAM");
        chk(20'h000EC, 1, 0, 1, 0, 8'hFF, "R1 ROM bound reset");
        chk(20'h000EB, 1, 0, 1, 0, 8'h00, "R1 RAM low reset");
        chk(20'h000EA, 1, 0, 1, 0, 8'h00, "R1 RAM high reset");
        chk(20'h000ED, 1, 0, 1, 0, 8'h00, "R1 config reset");
        // R2 program windows
        wr(20'h000EC, 8'h0F);
        wr(20'h000EB, 8'h10);
        wr(20'h000EA, 8'h7F);
        chk(20'h000EC, 1, 0, 1, 0, 8'h0F, "R2 read ROM bound");
        chk(20'h000EB, 1, 0, 1, 0, 8'h10, "R2 read RAM low");
        chk(20'h000EA, 1, 0, 1, 0, 8'h7F, "R2 read RAM high");
        // R4 / R5 boundary probes
        chk(20'h0FFFF, 0, 0, 1, 0, 8'h00, "R4 at ROM bound");
        chk(20'h10000, 0, 1, 0, 0, 8'h00, "R5 at RAM low");
        chk(20'h7FFFF, 0, 1, 0, 0, 8'h00, "R5 at RAM high");
        chk(20'h80000, 0, 1, 1, 0, 8'h00, "R5 above RAM high");
        // R6 / R9 strobe has no effect on selects; unmatched read gives 0
        chk(20'h10000, 1, 1, 0, 0, 8'h00, "R6 R9 read strobe");
        // R5 overlap priority
        wr(20'h000EB, 8'h08);
        chk(20'h08000, 0, 0, 1, 0, 8'h00, "R5 ROM priority in overlap");
        // R3 decode on low byte only
        wr(20'h0006A, 8'hAA);
        wr(20'h000EE, 8'h55);
        wr(20'h120EC, 8'h20);
        chk(20'h000EA, 1, 0, 1, 0, 8'h7F, "R3 RAM high untouched");
        chk(20'h000EB, 1, 0, 1, 0, 8'h08, "R3 RAM low untouched");
        chk(20'h000EC, 1, 0, 1, 0, 8'h20, "R3 upper bits ignored");
        chk(20'h20000, 0, 0, 1, 0, 8'h00, "R3 R4 new ROM bound");
        chk(20'h21000, 0, 1, 0, 0, 8'h00, "R4 past new ROM bound");
        // R7 ROM off and config masking, R8 expose
        wr(20'h000ED, 8'hFF);
        chk(20'h000ED, 1, 1, 1, 1, 8'h22, "R7 R8 config read");
        chk(20'h08000, 0, 1, 0, 0, 8'h00, "R7 RAM under disabled ROM");
        chk(20'h0006A, 1, 1, 1, 0, 8'h00, "R8 R9 unmatched read");
        chk(20'h000EB, 1, 1, 1, 1, 8'h08, "R8 exposed read");
        wr(20'h000ED, 8'h20);
        chk(20'h000EB, 1, 1, 1, 0, 8'h08, "R8 expose off");
        wr(20'h000ED, 8'h00);
        chk(20'h00000, 0, 0, 1, 0, 8'h00, "R7 ROM re-enabled");
        repeat (3) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule